// File: doc/BRIEF.md
# TLB Array Access Port

This block gives a CPU register bus direct read and write reach into the entry storage of two translation lookaside buffers: a small instruction TLB (4 entries by default) and a larger unified TLB (64 entries by default). Every entry holds an address word, which carries the virtual page number, a valid flag and a data word. Unified-TLB entries also hold a dirty flag. Both kinds of entry hold a 4-bit assistance field. The top byte of the bus address selects one of four arrays. A few address bits just above the byte offset pick the entry.

Software uses the port to load, inspect and invalidate translations. Besides indexed access, a write to the unified-TLB address array with address bit 7 set acts as a search. The page number carried in the written word is compared in parallel against every entry of both TLBs, and the valid and dirty flags of every matching entry are rewritten in the same clock. Every access, whether it hits a mapped array or not, is answered by a ready pulse one cycle later. Read data is presented with that pulse.

Top module: `tlb_access_port`

## Requirements
- R1: For every cycle with `reqValid` high, `rspReady` is high in the following cycle, and it is low otherwise. With the pulse, `rspRdata` carries the read result, or zero for a write. While no access is made, `rspRdata` holds its last value.
- R2: Only top address bytes 0xF2 (instruction address array), 0xF3 (instruction data array), 0xF6 (unified address array) and 0xF7 (unified data array) are mapped. A read of any other byte returns zero, and a write to any other byte changes no entry.
- R3: The instruction-TLB entry is chosen by address bits [9:8] and the unified-TLB entry by bits [13:8]. Other middle address bits do not alter the choice.
- R4: An indexed address-array write stores the data with bits 9 and 8 cleared, sets the valid flag from data bit 8 and, for the unified TLB only, sets the dirty flag from data bit 9.
- R5: A unified address-array read returns the stored word with valid in bit 8 and dirty in bit 9. An instruction address-array read returns the stored word with valid in bit 8 and bit 9 zero.
- R6: A data-array write with address bit 23 clear stores the full 32-bit word. With bit 23 set it stores only data[3:0] into the assistance field and leaves the data word unchanged.
- R7: A data-array read with address bit 23 clear returns the data word. With bit 23 set it returns the assistance field zero-extended.
- R8: A unified address-array write with address bit 7 set does not perform an indexed write. Instead, every matching entry in both TLBs takes valid from data bit 8, and every matching unified entry takes dirty from data bit 9. Address words, data words and non-matching entries are unchanged.
- R9: An entry matches the search page number data[31:10] only when it is valid. The compared bits depend on the entry's size field, data-word bits [5:4]: 0 compares bits [31:10], 1 compares bits [31:12], 2 compares bits [31:16], and 3 compares bits [31:20].
- R10: After reset every entry is invalid and clean, all words and assistance fields are zero, and `rspReady` and `rspRdata` are zero.
- R11: Address bit 7 has no effect on writes to the instruction address array. Such a write is always indexed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Access request this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 32 | Access address |
| reqWdata | input | 32 | Write data |
| rspReady | output | 1 | Access completed, one cycle after the request |
| rspRdata | output | 32 | Read result, zero after writes |

## Verification
The bench loads every unified entry with a mix of page sizes, valid flags and overlapping page numbers. It then issues searches that fall inside some pages and just outside others. A design that ignored the size mask would flip flags on 1 MB pages that should be skipped, or miss the coarse-page hits. A design that let invalid entries match would turn them valid. Aliased indices and bit-23 data writes are checked to confirm that an indexed write reaches exactly one entry and leaves the data word alone. Unmapped writes and a bit-7 write to the instruction array are followed by readbacks, which would show any entry that was corrupted or searched by mistake.

// File: rtl/tlb_port_pkg.sv
package tlb_port_pkg;

  localparam logic [7:0] SEL_I_ADDR = 8'hF2;
  localparam logic [7:0] SEL_I_DATA = 8'hF3;
  localparam logic [7:0] SEL_U_ADDR = 8'hF6;
  localparam logic [7:0] SEL_U_DATA = 8'hF7;

  // bits of an address word that are stored (flag positions are cleared)
  localparam logic [31:0] ADDR_KEEP = 32'hFFFF_FCFF;
  // position of the 2-bit page-size field inside a data word
  localparam int SIZE_LSB = 4;
  localparam int VPN_W = 22;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_IADDR,
    RD_IDATA,
    RD_UADDR,
    RD_UDATA
  } rdSel_e;

  typedef struct packed {
    logic   access;
    logic   iAddrWr;
    logic   iDataWr;
    logic   uAddrWr;
    logic   uDataWr;
    logic   assocWr;
    logic   assistSel;
    rdSel_e rdSel;
  } strobe_t;

  // which page-number bits take part in a compare, by size code
  function automatic logic [VPN_W-1:0] sizeMask(input logic [1:0] sz);
    case (sz)
      2'd0:    return 22'h3F_FFFF;
      2'd1:    return 22'h3F_FFFC;
      2'd2:    return 22'h3F_FFC0;
      default: return 22'h3F_FC00;
    endcase
  endfunction

endpackage

// File: rtl/tlb_entry_match.sv
module tlb_entry_match
  import tlb_port_pkg::*;
(
  input  logic [VPN_W-1:0] entryVpn,
  input  logic             entryValid,
  input  logic [1:0]       entrySize,
  input  logic [VPN_W-1:0] searchVpn,
  output logic             hit
);
  logic [VPN_W-1:0] diff;

  always_comb begin
    diff = (entryVpn ^ searchVpn) & sizeMask(entrySize);
    hit  = entryValid && (diff == '0);
  end
endmodule

// File: rtl/tlb_port_ctrl.sv
module tlb_port_ctrl
  import tlb_port_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reqValid,
  input  logic       reqWrite,
  input  logic [7:0] selByte,
  input  logic       assistBit,
  input  logic       assocBit,
  output strobe_t    stb,
  output logic       rspReady
);

  always_comb begin
    stb = '0;
    stb.rdSel = RD_NONE;
    if (reqValid) begin
      stb.access    = 1'b1;
      stb.assistSel = assistBit;
      case (selByte)
        SEL_I_ADDR: if (reqWrite) stb.iAddrWr = 1'b1; else stb.rdSel = RD_IADDR;
        SEL_I_DATA: if (reqWrite) stb.iDataWr = 1'b1; else stb.rdSel = RD_IDATA;
        SEL_U_ADDR: begin
          if (reqWrite) begin
            if (assocBit) stb.assocWr = 1'b1;
            else          stb.uAddrWr = 1'b1;
          end else begin
            stb.rdSel = RD_UADDR;
          end
        end
        SEL_U_DATA: if (reqWrite) stb.uDataWr = 1'b1; else stb.rdSel = RD_UDATA;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rspReady <= 1'b0;
    else        rspReady <= reqValid;
  end
endmodule

// File: rtl/tlb_port_dp.sv
module tlb_port_dp
  import tlb_port_pkg::*;
#(
  parameter int ITLB_ENTRIES = 4,
  parameter int UTLB_ENTRIES = 64,
  localparam int IIW = $clog2(ITLB_ENTRIES),
  localparam int UIW = $clog2(UTLB_ENTRIES)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  strobe_t        stb,
  input  logic [IIW-1:0] iIdx,
  input  logic [UIW-1:0] uIdx,
  input  logic [31:0]    wdata,
  output logic [31:0]    rdata
);

  logic [31:0] iAddrQ   [ITLB_ENTRIES];
  logic [31:0] iDataQ   [ITLB_ENTRIES];
  logic [3:0]  iAssistQ [ITLB_ENTRIES];
  logic [ITLB_ENTRIES-1:0] iValidQ;

  logic [31:0] uAddrQ   [UTLB_ENTRIES];
  logic [31:0] uDataQ   [UTLB_ENTRIES];
  logic [3:0]  uAssistQ [UTLB_ENTRIES];
  logic [UTLB_ENTRIES-1:0] uValidQ;
  logic [UTLB_ENTRIES-1:0] uDirtyQ;

  logic [ITLB_ENTRIES-1:0] iHit;
  logic [UTLB_ENTRIES-1:0] uHit;
  logic [VPN_W-1:0] searchVpn;
  logic [31:0] readMux;

  assign searchVpn = wdata[31:10];

  // parallel page compare, one comparator per entry
  for (genvar g = 0; g < ITLB_ENTRIES; g++) begin : gIMatch
    tlb_entry_match uMatch (
      .entryVpn  (iAddrQ[g][31:10]),
      .entryValid(iValidQ[g]),
      .entrySize (iDataQ[g][SIZE_LSB +: 2]),
      .searchVpn (searchVpn),
      .hit       (iHit[g])
    );
  end

  for (genvar g = 0; g < UTLB_ENTRIES; g++) begin : gUMatch
    tlb_entry_match uMatch (
      .entryVpn  (uAddrQ[g][31:10]),
      .entryValid(uValidQ[g]),
      .entrySize (uDataQ[g][SIZE_LSB +: 2]),
      .searchVpn (searchVpn),
      .hit       (uHit[g])
    );
  end

  // instruction TLB storage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ITLB_ENTRIES; i++) begin
        iAddrQ[i]   <= '0;
        iDataQ[i]   <= '0;
        iAssistQ[i] <= '0;
      end
      iValidQ <= '0;
    end else begin
      if (stb.iAddrWr) begin
        iAddrQ[iIdx]  <= wdata & ADDR_KEEP;
        iValidQ[iIdx] <= wdata[8];
      end
      if (stb.assocWr) begin
        for (int i = 0; i < ITLB_ENTRIES; i++)
          if (iHit[i]) iValidQ[i] <= wdata[8];
      end
      if (stb.iDataWr) begin
        if (stb.assistSel) iAssistQ[iIdx] <= wdata[3:0];
        else               iDataQ[iIdx]   <= wdata;
      end
    end
  end

  // unified TLB storage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < UTLB_ENTRIES; i++) begin
        uAddrQ[i]   <= '0;
        uDataQ[i]   <= '0;
        uAssistQ[i] <= '0;
      end
      uValidQ <= '0;
      uDirtyQ <= '0;
    end else begin
      if (stb.uAddrWr) begin
        uAddrQ[uIdx]  <= wdata & ADDR_KEEP;
        uValidQ[uIdx] <= wdata[8];
        uDirtyQ[uIdx] <= wdata[9];
      end
      if (stb.assocWr) begin
        for (int i = 0; i < UTLB_ENTRIES; i++)
          if (uHit[i]) begin
            uValidQ[i] <= wdata[8];
            uDirtyQ[i] <= wdata[9];
          end
      end
      if (stb.uDataWr) begin
        if (stb.assistSel) uAssistQ[uIdx] <= wdata[3:0];
        else               uDataQ[uIdx]   <= wdata;
      end
    end
  end

  // readback formatting
  always_comb begin
    case (stb.rdSel)
      RD_IADDR: readMux = iAddrQ[iIdx] | {23'b0, iValidQ[iIdx], 8'b0};
      RD_IDATA: readMux = stb.assistSel ? {28'b0, iAssistQ[iIdx]} : iDataQ[iIdx];
      RD_UADDR: readMux = uAddrQ[uIdx] | {22'b0, uDirtyQ[uIdx], uValidQ[uIdx], 8'b0};
      RD_UDATA: readMux = stb.assistSel ? {28'b0, uAssistQ[uIdx]} : uDataQ[uIdx];
      default:  readMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          rdata <= '0;
    else if (stb.access) rdata <= readMux;
  end
endmodule

// File: rtl/tlb_access_port.sv
module tlb_access_port
  import tlb_port_pkg::*;
#(
  parameter int ITLB_ENTRIES = 4,
  parameter int UTLB_ENTRIES = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic [31:0] reqAddr,
  input  logic [31:0] reqWdata,
  output logic        rspReady,
  output logic [31:0] rspRdata
);
  localparam int IIW = $clog2(ITLB_ENTRIES);
  localparam int UIW = $clog2(UTLB_ENTRIES);

  strobe_t stb;
  logic    unusedAddr;

  assign unusedAddr = ^reqAddr;

  tlb_port_ctrl uCtrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .selByte  (reqAddr[31:24]),
    .assistBit(reqAddr[23]),
    .assocBit (reqAddr[7]),
    .stb      (stb),
    .rspReady (rspReady)
  );

  tlb_port_dp #(
    .ITLB_ENTRIES(ITLB_ENTRIES),
    .UTLB_ENTRIES(UTLB_ENTRIES)
  ) uDp (
    .clk  (clk),
    .rst_n(rst_n),
    .stb  (stb),
    .iIdx (reqAddr[8 +: IIW]),
    .uIdx (reqAddr[8 +: UIW]),
    .wdata(reqWdata),
    .rdata(rspRdata)
  );
endmodule

// File: rtl/tlb_access_port_chk.sv
module tlb_access_port_chk
  import tlb_port_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        reqValid,
  input logic        reqWrite,
  input logic [31:0] reqAddr,
  input logic        rspReady,
  input logic [31:0] rspRdata
);
  logic mapped;
  logic isRead;
  assign mapped = (reqAddr[31:24] == SEL_I_ADDR) || (reqAddr[31:24] == SEL_I_DATA) ||
                  (reqAddr[31:24] == SEL_U_ADDR) || (reqAddr[31:24] == SEL_U_DATA);
  assign isRead = reqValid && !reqWrite;

  assert_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid |=> rspReady);
  assert_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !reqValid |=> !rspReady);
  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !reqValid |=> $stable(rspRdata));
  assert_wr_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && reqWrite) |=> (rspRdata == 32'h0));
  assert_unmapped_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (isRead && !mapped) |=> (rspRdata == 32'h0));
  assert_iaddr_fmt_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (isRead && reqAddr[31:24] == SEL_I_ADDR) |=> !rspRdata[9]);
  assert_assist_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (isRead && reqAddr[23] && (reqAddr[31:24] == SEL_I_DATA || reqAddr[31:24] == SEL_U_DATA))
      |=> (rspRdata[31:4] == 28'h0));
endmodule

bind tlb_access_port tlb_access_port_chk uChk (
  .clk     (clk),
  .rst_n   (rst_n),
  .reqValid(reqValid),
  .reqWrite(reqWrite),
  .reqAddr (reqAddr),
  .rspReady(rspReady),
  .rspRdata(rspRdata)
);

// File: tb/tlb_access_port_test.sv
`timescale 1ns/1ps
module tlb_access_port_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [31:0] reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic        rspReady;
  logic [31:0] rspRdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tlb_access_port uut (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .rspReady(rspReady), .rspRdata(rspRdata)
  );

  // reference model, built from the requirements
  logic [31:0] mUaddr [64];
  logic [31:0] mUdata [64];
  logic [3:0]  mUas   [64];
  logic        mUv    [64];
  logic        mUd    [64];
  logic [31:0] mIaddr [4];
  logic [31:0] mIdata [4];
  logic [3:0]  mIas   [4];
  logic        mIv    [4];

  typedef struct { logic [31:0] exp; string tag; } item_t;
  item_t sb[$];

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic bit mHit(input logic [31:0] aw, input logic [31:0] dw, input logic v, input logic [21:0] sv);
    logic [21:0] m;
    case (dw[5:4])
      2'd0: m = 22'h3FFFFF;
      2'd1: m = 22'h3FFFFC;
      2'd2: m = 22'h3FFFC0;
      default: m = 22'h3FFC00;
    endcase
    return v && (((aw[31:10] ^ sv) & m) == 22'h0);
  endfunction

  function automatic logic [31:0] mRead(input logic [31:0] a);
    case (a[31:24])
      8'hF2: return mIaddr[a[9:8]] | {23'b0, mIv[a[9:8]], 8'b0};
      8'hF3: return a[23] ? {28'b0, mIas[a[9:8]]} : mIdata[a[9:8]];
      8'hF6: return mUaddr[a[13:8]] | {22'b0, mUd[a[13:8]], mUv[a[13:8]], 8'b0};
      8'hF7: return a[23] ? {28'b0, mUas[a[13:8]]} : mUdata[a[13:8]];
      default: return 32'h0;
    endcase
  endfunction

  task automatic mWrite(input logic [31:0] a, input logic [31:0] d);
    bit uh [64];
    bit ih [4];
    case (a[31:24])
      8'hF2: begin mIaddr[a[9:8]] = d & 32'hFFFFFCFF; mIv[a[9:8]] = d[8]; end
      8'hF3: if (a[23]) mIas[a[9:8]] = d[3:0]; else mIdata[a[9:8]] = d;
      8'hF6: begin
        if (a[7]) begin
          for (int i = 0; i < 64; i++) uh[i] = mHit(mUaddr[i], mUdata[i], mUv[i], d[31:10]);
          for (int i = 0; i < 4; i++)  ih[i] = mHit(mIaddr[i], mIdata[i], mIv[i], d[31:10]);
          for (int i = 0; i < 64; i++) if (uh[i]) begin mUv[i] = d[8]; mUd[i] = d[9]; end
          for (int i = 0; i < 4; i++)  if (ih[i]) mIv[i] = d[8];
        end else begin
          mUaddr[a[13:8]] = d & 32'hFFFFFCFF; mUv[a[13:8]] = d[8]; mUd[a[13:8]] = d[9];
        end
      end
      8'hF7: if (a[23]) mUas[a[13:8]] = d[3:0]; else mUdata[a[13:8]] = d;
      default: ;
    endcase
  endtask

  // driver: push the expected response, then drive one access and check the idle hold
  task automatic access(input bit wr, input logic [31:0] a, input logic [31:0] d, input string tag);
    logic [31:0] e;
    e = wr ? 32'h0 : mRead(a);
    if (wr) mWrite(a, d);
    sb.push_back('{exp: e, tag: tag});
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d;
    @(negedge clk);
    reqValid = 1'b0; reqWrite = 1'b0;
    @(negedge clk);
    check(!rspReady && rspRdata == e, "R1 idle hold", rspRdata, e);
  endtask

  // monitor: pop and compare on every response
  always @(negedge clk) begin
    if (rst_n && rspReady) begin
      if (sb.size() == 0) begin
        check(1'b0, "R1 unexpected response", rspRdata, 32'h0);
      end else begin
        item_t it;
        it = sb.pop_front();
        check(rspRdata == it.exp, it.tag, rspRdata, it.exp);
      end
    end
  end

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) begin mUaddr[i] = 0; mUdata[i] = 0; mUas[i] = 0; mUv[i] = 0; mUd[i] = 0; end
    for (int i = 0; i < 4; i++) begin mIaddr[i] = 0; mIdata[i] = 0; mIas[i] = 0; mIv[i] = 0; end
    repeat (3) @(negedge clk);
    check(rspReady == 1'b0 && rspRdata == 32'h0, "R10 reset outputs", rspRdata, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: all arrays read zero after reset
    for (int i = 0; i < 64; i++) begin
      access(0, 32'hF600_0000 | (i << 8), 0, "R10 reset utlb addr");
      access(0, 32'hF700_0000 | (i << 8), 0, "R10 reset utlb data");
    end
    for (int i = 0; i < 4; i++) begin
      access(0, 32'hF200_0000 | (i << 8), 0, "R10 reset itlb addr");
      access(0, 32'hF380_0000 | (i << 8), 0, "R10 reset itlb assist");
    end

    // R4, R5: indexed address writes and flag placement
    access(1, 32'hF600_0500, 32'h1234_5FFF, "R4 utlb addr write");
    access(0, 32'hF600_0500, 0, "R5 utlb addr read V D");
    access(1, 32'hF600_0600, 32'hABCD_E1A5, "R4 utlb addr write v only");
    access(0, 32'hF600_0600, 0, "R5 utlb addr read v only");
    access(1, 32'hF200_0100, 32'h5555_5355, "R4 itlb addr write");
    access(0, 32'hF200_0100, 0, "R5 itlb addr read no dirty");

    // R3: index aliasing, upper middle bits ignored
    access(1, 32'hF200_3E00, 32'h7000_0100, "R3 itlb alias write");
    access(0, 32'hF200_0200, 0, "R3 itlb alias read");
    access(1, 32'hF67F_C700, 32'h6000_0300, "R3 utlb alias write");
    access(0, 32'hF600_0700, 0, "R3 utlb alias read");

    // R11: bit 7 on the instruction address array is an indexed write
    access(1, 32'hF200_0380, 32'h1234_5100, "R11 itlb bit7 write");
    access(0, 32'hF200_0300, 0, "R11 itlb bit7 read");

    // R6, R7: data words and assistance fields
    access(1, 32'hF700_0500, 32'hDEAD_BEEF, "R6 utlb data write");
    access(1, 32'hF780_0500, 32'hFFFF_FFF6, "R6 utlb assist write");
    access(0, 32'hF700_0500, 0, "R6 utlb data unchanged by assist");
    access(0, 32'hF780_0500, 0, "R7 utlb assist read");
    access(1, 32'hF300_0200, 32'hCAFE_0010, "R6 itlb data write");
    access(1, 32'hF380_0200, 32'h0000_000B, "R6 itlb assist write");
    access(0, 32'hF300_0200, 0, "R7 itlb data read");
    access(0, 32'hF380_0200, 0, "R7 itlb assist read");

    // R2: unmapped bytes
    access(1, 32'hF400_0500, 32'hFFFF_FFFF, "R2 unmapped write");
    access(1, 32'hFF00_0500, 32'hFFFF_FFFF, "R2 unmapped write ff");
    access(0, 32'hF400_0500, 0, "R2 unmapped read");
    access(0, 32'hF500_0000, 0, "R2 unmapped read f5");
    access(0, 32'hF600_0500, 0, "R2 entry untouched");
    access(0, 32'hF700_0500, 0, "R2 data untouched");

    // R8, R9: load all entries with mixed sizes and validity, then search
    for (int i = 0; i < 64; i++) begin
      logic [31:0] aw;
      aw = 32'h2000_0000 | ((i % 8) << 10) | ((i / 8) << 20) | (((i % 5) != 0) << 8);
      access(1, 32'hF700_0000 | (i << 8), (i % 4) << 4, "R9 load size");
      access(1, 32'hF600_0000 | (i << 8), aw, "R9 load page");
    end
    for (int i = 0; i < 4; i++) begin
      access(1, 32'hF300_0000 | (i << 8), 32'h0000_0000, "R9 load itlb size");
      access(1, 32'hF200_0000 | (i << 8), 32'h2000_0100 | (i << 10), "R9 load itlb page");
    end
    access(1, 32'hF600_0080, 32'h2000_0700, "R8 search set dirty");
    access(1, 32'hF600_0080, 32'h2030_0C00, "R8 search clear");
    access(1, 32'hF600_0080, 32'h2070_0B00, "R8 search 1MB group");
    access(1, 32'hF600_0080, 32'h2000_0400, "R8 search itlb hit clear");
    access(1, 32'hF600_0080, 32'h2050_1300, "R8 search 4KB group");
    access(1, 32'hF600_0080, 32'h2000_0000, "R9 invalid entries stay invalid");
    for (int i = 0; i < 64; i++) begin
      access(0, 32'hF600_0000 | (i << 8), 0, "R8 utlb flags after search");
      access(0, 32'hF700_0000 | (i << 8), 0, "R8 utlb data unchanged");
    end
    for (int i = 0; i < 4; i++)
      access(0, 32'hF200_0000 | (i << 8), 0, "R8 itlb flags after search");

    @(negedge clk);
    check(sb.size() == 0, "R1 all responses seen", sb.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule